// File: doc/BRIEF.md
# Register window counter controller

This block keeps the bookkeeping for a circular file of register windows. It holds a current-window pointer and four occupancy counters: windows that can be saved, windows that can be restored, windows known to be clean, and windows belonging to another context. It takes one command per cycle from the instruction pipeline. A command either updates that state or asks for a trap. A trap request carries a 9-bit trap type, and for spill and fill traps that type is built from a 6-bit window-state value.

The pointer leaves the block in its architectural orientation, which runs opposite to the internal one: visible = NWIN − 1 − internal. A pointer write is converted the same way. The register file itself, trap dispatch and the spill/fill handlers live elsewhere.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset, the visible pointer is NWIN−1, the save counter is NWIN−2, the clean counter is NWIN−1, and the restore counter, other counter, trap_valid and trap_type are all 0.
- R2: A save (op 1) with the save counter at zero raises a spill trap and leaves the pointer and all counters unchanged.
- R3: Spill traps use base 0x080 and fill traps use base 0x0C0. When the other counter is nonzero, the type is base | 0x020 | (win_state[5:3] << 2). When it is zero, the type is base | (win_state[2:0] << 2).
- R4: A save with a nonzero save counter, where clean minus restore (modulo counter width) is zero, raises trap type 0x024 and changes no state.
- R5: A successful save decrements the save counter, increments the restore counter and moves the internal pointer to (pointer − 1) mod NWIN, so the visible pointer goes up by one.
- R6: A restore (op 2) with the restore counter at zero raises a fill trap and changes nothing. Otherwise it increments the save counter, decrements the restore counter and moves the internal pointer to (pointer + 1) mod NWIN.
- R7: A saved command (op 3) increments the save counter. It then decrements the restore counter if the other counter is zero, or decrements the other counter if not.
- R8: A restored command (op 4) increments the restore counter. It increments the clean counter only while that counter is below NWIN−1. It then decrements the save counter if the other counter is zero, or decrements the other counter if not.
- R9: A flush command (op 5) raises a spill trap whenever the save counter differs from NWIN−2, and never changes state.
- R10: A pointer write (op 6) with value v sets the visible pointer to v. Internally it stores NWIN−1−v.
- R11: An other-load command (op 7) sets the other counter to cmd_data and changes nothing else.
- R12: trap_valid is high for exactly the one cycle after a trapping command and carries its type. trap_type reads 0 whenever trap_valid is low. Op 0, or cmd_valid low, does nothing. All counters wrap modulo 2^log2(NWIN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (0 nop, 1 save, 2 restore, 3 saved, 4 restored, 5 flush, 6 pointer write, 7 other-load) |
| cmd_data | input | log2(NWIN) | Write data for ops 6 and 7 |
| win_state | input | 6 | Window-state fields used in spill/fill trap types |
| win_ptr | output | log2(NWIN) | Visible current-window pointer |
| cnt_save | output | log2(NWIN) | Save counter |
| cnt_restore | output | log2(NWIN) | Restore counter |
| cnt_clean | output | log2(NWIN) | Clean counter |
| cnt_other | output | log2(NWIN) | Other counter |
| trap_valid | output | 1 | One-cycle trap request |
| trap_type | output | 9 | Trap type, zero when no trap |

## Verification
All of the state is visible at the ports. A wrong counter or pointer update therefore shows on the edge that performs it, and it is caught at the following sample. A wrong trap decision or trap type appears on trap_valid and trap_type one cycle after the command. It also shows as a counter that moved when it should have stayed put, or stayed put when it should have moved. A corrupted counter also steers later decisions, so a random command stream lets an early error spread into later trap mismatches. Directed sequences cover the boundaries: saving until the save counter empties, restoring until the restore counter empties, the clean counter reaching its cap, and counter wrap.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int TT_W = 9;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_SAVE     = 3'd1,
    OP_RESTORE  = 3'd2,
    OP_SAVED    = 3'd3,
    OP_RESTORED = 3'd4,
    OP_FLUSH    = 3'd5,
    OP_SETPTR   = 3'd6,
    OP_SETOTHER = 3'd7
  } win_op_e;

  localparam logic [TT_W-1:0] TT_SPILL = 9'h080;
  localparam logic [TT_W-1:0] TT_FILL  = 9'h0C0;
  localparam logic [TT_W-1:0] TT_CLEAN = 9'h024;
  localparam logic [TT_W-1:0] TT_OTHER = 9'h020;

  // Update events produced by the decision stage, consumed by the state stage
  typedef struct packed {
    logic save_ok;
    logic restore_ok;
    logic saved;
    logic restored;
    logic set_ptr;
    logic set_other;
  } win_upd_t;

  // Spill/fill vector composition from the window-state fields
  function automatic logic [TT_W-1:0] compose_tt(input logic [TT_W-1:0] base,
                                                 input logic other_nz,
                                                 input logic [5:0] ws);
    logic [TT_W-1:0] fld;
    if (other_nz) fld = TT_OTHER | {4'b0, ws[5:3], 2'b00};
    else          fld = {4'b0, ws[2:0], 2'b00};
    return base | fld;
  endfunction

endpackage

// File: rtl/regwin_trapenc.sv
module regwin_trapenc
  import regwin_pkg::*;
(
  input  logic            is_fill,
  input  logic            other_nz,
  input  logic [5:0]      ws,
  output logic [TT_W-1:0] tt
);

  always_comb begin
    tt = compose_tt(is_fill ? TT_FILL : TT_SPILL, other_nz, ws);
  end

endmodule

// File: rtl/regwin_decide.sv
module regwin_decide
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            valid,
  input  logic [2:0]      op,
  input  logic [CW-1:0]   cansave,
  input  logic [CW-1:0]   canrestore,
  input  logic [CW-1:0]   cleanwin,
  input  logic [CW-1:0]   otherwin,
  input  logic [5:0]      ws,
  output win_upd_t        upd,
  output logic            trap_req,
  output logic [TT_W-1:0] trap_tt
);

  localparam logic [CW-1:0] FLUSH_LVL = CW'(NWIN - 2);

  logic            is_fill;
  logic            is_clean;
  logic [TT_W-1:0] sf_tt;
  logic [CW-1:0]   clean_gap;
  win_op_e         opc;

  assign opc       = win_op_e'(op);
  assign clean_gap = cleanwin - canrestore;

  regwin_trapenc u_enc (
    .is_fill  (is_fill),
    .other_nz (otherwin != '0),
    .ws       (ws),
    .tt       (sf_tt)
  );

  always_comb begin
    upd      = '0;
    trap_req = 1'b0;
    is_fill  = 1'b0;
    is_clean = 1'b0;
    if (valid) begin
      unique case (opc)
        OP_SAVE: begin
          if (cansave == '0) begin
            trap_req = 1'b1;
          end else if (clean_gap == '0) begin
            trap_req = 1'b1;
            is_clean = 1'b1;
          end else begin
            upd.save_ok = 1'b1;
          end
        end
        OP_RESTORE: begin
          if (canrestore == '0) begin
            trap_req = 1'b1;
            is_fill  = 1'b1;
          end else begin
            upd.restore_ok = 1'b1;
          end
        end
        OP_SAVED:    upd.saved     = 1'b1;
        OP_RESTORED: upd.restored  = 1'b1;
        OP_FLUSH:    trap_req      = (cansave != FLUSH_LVL);
        OP_SETPTR:   upd.set_ptr   = 1'b1;
        OP_SETOTHER: upd.set_other = 1'b1;
        default: ;
      endcase
    end
  end

  assign trap_tt = is_clean ? TT_CLEAN : sf_tt;

endmodule

// File: rtl/regwin_state.sv
module regwin_state
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  win_upd_t      upd,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore,
  output logic [CW-1:0] cleanwin,
  output logic [CW-1:0] otherwin
);

  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  function automatic logic [CW-1:0] flip_ptr(input logic [CW-1:0] p);
    return TOP - p;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp        <= '0;
      cansave    <= CW'(NWIN - 2);
      canrestore <= '0;
      cleanwin   <= TOP;
      otherwin   <= '0;
    end else begin
      if (upd.save_ok) begin
        cwp        <= cwp - 1'b1;
        cansave    <= cansave - 1'b1;
        canrestore <= canrestore + 1'b1;
      end
      if (upd.restore_ok) begin
        cwp        <= cwp + 1'b1;
        cansave    <= cansave + 1'b1;
        canrestore <= canrestore - 1'b1;
      end
      if (upd.saved) begin
        cansave <= cansave + 1'b1;
        if (otherwin == '0) canrestore <= canrestore - 1'b1;
        else                otherwin   <= otherwin - 1'b1;
      end
      if (upd.restored) begin
        canrestore <= canrestore + 1'b1;
        if (cleanwin < TOP) cleanwin <= cleanwin + 1'b1;
        if (otherwin == '0) cansave  <= cansave - 1'b1;
        else                otherwin <= otherwin - 1'b1;
      end
      if (upd.set_ptr)   cwp      <= flip_ptr(wdata);
      if (upd.set_other) otherwin <= wdata;
    end
  end

  AST_SAVE_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd.save_ok |=> cwp == $past(cwp) - 1'b1); // R5
  AST_RESTORE_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd.restore_ok |=> cwp == $past(cwp) + 1'b1); // R6
  AST_CLEAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd.restored && cleanwin == TOP) |=> cleanwin == TOP); // R8
  AST_OTHER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    upd.set_other |=> (otherwin == $past(wdata)) && $stable(cansave) && $stable(canrestore)); // R11

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [CW-1:0]   cmd_data,
  input  logic [5:0]      win_state,
  output logic [CW-1:0]   win_ptr,
  output logic [CW-1:0]   cnt_save,
  output logic [CW-1:0]   cnt_restore,
  output logic [CW-1:0]   cnt_clean,
  output logic [CW-1:0]   cnt_other,
  output logic            trap_valid,
  output logic [TT_W-1:0] trap_type
);

  win_upd_t        upd;
  logic            trap_req;
  logic [TT_W-1:0] trap_tt;
  logic [CW-1:0]   cwp_int;

  regwin_decide #(.NWIN(NWIN)) u_decide (
    .valid      (cmd_valid),
    .op         (cmd_op),
    .cansave    (cnt_save),
    .canrestore (cnt_restore),
    .cleanwin   (cnt_clean),
    .otherwin   (cnt_other),
    .ws         (win_state),
    .upd        (upd),
    .trap_req   (trap_req),
    .trap_tt    (trap_tt)
  );

  regwin_state #(.NWIN(NWIN)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (upd),
    .wdata      (cmd_data),
    .cwp        (cwp_int),
    .cansave    (cnt_save),
    .canrestore (cnt_restore),
    .cleanwin   (cnt_clean),
    .otherwin   (cnt_other)
  );

  assign win_ptr = CW'(NWIN - 1) - cwp_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_type  <= '0;
    end else begin
      trap_valid <= trap_req;
      trap_type  <= trap_req ? trap_tt : '0;
    end
  end

  AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> $stable(cnt_save) && $stable(cnt_restore) && $stable(cnt_clean)
                 && $stable(cnt_other) && $stable(win_ptr)); // R2
  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(cmd_valid)); // R12
  AST_TYPE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |-> trap_type == '0); // R12
  AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd, trap_req})); // R12
  AST_FLUSH_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |-> upd == '0); // R9

endmodule

// File: tb/test_regwin_ctrl.sv
module test_regwin_ctrl;

  localparam int NW = 8;
  localparam int PW = $clog2(NW);
  localparam int M  = NW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [PW-1:0] cmd_data = '0;
  logic [5:0]    win_state = '0;
  logic [PW-1:0] win_ptr, cnt_save, cnt_restore, cnt_clean, cnt_other;
  logic          trap_valid;
  logic [8:0]    trap_type;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state (internal pointer orientation)
  int m_cwp, m_cs, m_cr, m_cl, m_ow, m_tv, m_tt;

  regwin_ctrl #(.NWIN(NW)) i_regwin_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .win_state(win_state), .win_ptr(win_ptr),
    .cnt_save(cnt_save), .cnt_restore(cnt_restore), .cnt_clean(cnt_clean),
    .cnt_other(cnt_other), .trap_valid(trap_valid), .trap_type(trap_type)
  );

  always #10 clk = ~clk;

  function automatic int sf_type(int base);
    int ws = int'(win_state);
    if (m_ow != 0) return base + 32 + (((ws / 8) % 8) * 4);
    return base + ((ws % 8) * 4);
  endfunction

  task automatic model(int op, int d);
    m_tv = 0; m_tt = 0;
    case (op)
      1: if (m_cs == 0) begin m_tv = 1; m_tt = sf_type(128); end
         else if (((m_cl - m_cr) & M) == 0) begin m_tv = 1; m_tt = 36; end
         else begin m_cs = (m_cs - 1) & M; m_cr = (m_cr + 1) & M; m_cwp = (m_cwp - 1) & M; end
      2: if (m_cr == 0) begin m_tv = 1; m_tt = sf_type(192); end
         else begin m_cs = (m_cs + 1) & M; m_cr = (m_cr - 1) & M; m_cwp = (m_cwp + 1) & M; end
      3: begin m_cs = (m_cs + 1) & M;
         if (m_ow == 0) m_cr = (m_cr - 1) & M; else m_ow = m_ow - 1; end
      4: begin m_cr = (m_cr + 1) & M;
         if (m_cl < NW - 1) m_cl = m_cl + 1;
         if (m_ow == 0) m_cs = (m_cs - 1) & M; else m_ow = m_ow - 1; end
      5: if (m_cs != NW - 2) begin m_tv = 1; m_tt = sf_type(128); end
      6: m_cwp = (NW - 1 - d) & M;
      7: m_ow = d & M;
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    int exp_ptr = (NW - 1 - m_cwp) & M;
    checks++;
    if (int'(win_ptr) != exp_ptr || int'(cnt_save) != m_cs || int'(cnt_restore) != m_cr ||
        int'(cnt_clean) != m_cl || int'(cnt_other) != m_ow || int'(trap_valid) != m_tv ||
        int'(trap_type) != m_tt) begin
      errors++;
      $display("FAIL %s actual ptr=%0d cs=%0d cr=%0d cl=%0d ow=%0d tv=%0d tt=%h expected ptr=%0d cs=%0d cr=%0d cl=%0d ow=%0d tv=%0d tt=%h",
               tag, win_ptr, cnt_save, cnt_restore, cnt_clean, cnt_other, trap_valid, trap_type,
               exp_ptr, m_cs, m_cr, m_cl, m_ow, m_tv, m_tt);
    end
  endtask

  // called at a negedge; applies a command for one cycle and checks after the edge
  task automatic step(int op, int d, string tag, bit valid = 1);
    cmd_valid = valid;
    cmd_op    = op[2:0];
    cmd_data  = d[PW-1:0];
    if (valid) model(op, d & M); else model(0, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    m_cwp = 0; m_cs = NW - 2; m_cr = 0; m_cl = NW - 1; m_ow = 0; m_tv = 0; m_tt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    compare("R1 reset state");

    // R9: flush at the reset level does not trap
    step(5, 0, "R9 flush at NWIN-2");
    // R5: one save
    step(1, 0, "R5 save ok");
    // R9/R3: flush now traps with spill type from win_state[2:0]
    win_state = 6'b101_011;
    step(5, 0, "R9 flush trap, R3 type");
    step(0, 0, "R12 pulse ends");
    // R5: drain the save counter, then R2 spill
    for (int k = 0; k < NW - 3; k++) step(1, 0, "R5 save run");
    step(1, 0, "R2 spill on empty save counter");
    step(1, 0, "R2 repeated spill");
    // R12: invalid command is ignored
    step(2, 0, "R12 cmd_valid low ignored", 0);
    // R6: restore back to empty, then fill
    for (int k = 0; k < NW - 2; k++) step(2, 0, "R6 restore run");
    step(2, 0, "R6 fill on empty restore counter, R3 fill base");
    // R11 and R3 other path
    step(7, 3, "R11 other load");
    win_state = 6'b110_001;
    step(2, 0, "R3 fill type with other nonzero");
    // R7 saved with other nonzero, then with zero
    step(3, 0, "R7 saved other path");
    step(7, 0, "R11 other clear");
    step(1, 0, "R5 save");
    step(3, 0, "R7 saved restore path");
    // R10 pointer writes
    step(6, 2, "R10 pointer write");
    step(6, 7, "R10 pointer write top");
    step(1, 0, "R5 save from written pointer");
    // R8/R4: restored until restore counter reaches clean counter, then clean trap
    do_reset();
    for (int k = 0; k < NW - 1; k++) step(4, 0, "R8 restored run");
    step(1, 0, "R4 clean-window trap");
    step(7, 1, "R11 other load");
    step(4, 0, "R8 restored other path, clean cap");

    // random stream against the model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(0, 15) == 0) win_state = 6'($urandom);
      step($urandom_range(0, 7), $urandom_range(0, M), "R12 random stream",
           $urandom_range(0, 9) != 0);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule